// File: doc/BRIEF.md
# ASID-Ring Translation Buffer with Permission Check

This block is a small set-associative translation buffer that turns a virtual address into a physical address for one side of a processor, either data accesses or instruction fetches. A parameter selects the side. Each entry holds a virtual page number, a physical page number, an address-space identifier and a 4-bit attribute code. A lookup checks every way at the set chosen by the low page-number bits. A way counts as a hit only when its page number matches, its identifier is nonzero, and that identifier appears in one of the four byte lanes of a ring-map register. The lane index becomes the access ring.

The result is registered and appears one cycle after the request. It carries a fault cause, or, on success, the physical address, the ring, the granted rights and the cache mode. The fault causes cover a miss, two or more hits, a privilege violation, and a missing right. Entries are loaded through one write port. A direct write names its way and its identifier. A refill write takes a page-table entry, advances a rotating way pointer, and derives the identifier from the ring field of the entry. The page-table walk itself is done outside the block.

Top module: `asid_ring_tlb`

## Requirements
- R1: After reset the ring-map register reads 0x04030201, the refill pointer reads 0, and every entry is invalid, so any lookup reports a miss.
- R2: A way qualifies only when its stored page number equals vaddr[31:12], its identifier is nonzero, and the identifier equals a byte of the ring-map register. The reported ring is the index (0..3) of the lowest such byte. An identifier found in no byte never qualifies.
- R3: Two or more qualifying ways give cause 25 on the data side and 17 on the instruction side. No qualifying way gives cause 24 on the data side and 16 on the instruction side.
- R4: When a single way qualifies and its ring is numerically below lk_priv, the cause is 26 on the data side and 18 on the instruction side.
- R5: Attribute codes 0..11 grant read. Bit 0 of the code grants execute and bit 1 grants write. Code bits [3:2] select the cache mode: 0 gives bypass (rsp_cache 0), 1 gives write-back (1), 2 gives write-through (2). Code 13 grants read and write with cache-isolate (3). Codes 12, 14 and 15 grant nothing.
- R6: The data side drops execute and the instruction side drops read and write. rsp_rwx reports {read, write, execute}. A load lacking read gives cause 28 and a store lacking write gives cause 29. A fetch lacking execute gives cause 20. lk_store is ignored on the instruction side.
- R7: On success (cause 0) rsp_paddr is the entry's physical page number in bits [31:12] and vaddr[11:0] below it.
- R8: A refill write first increments the 2-bit refill pointer, then writes the way the new pointer value names. The entry's identifier is the ring-map byte selected by pte[5:4], its physical page is pte[31:12] and its attribute is pte[3:0].
- R9: rsp_valid rises exactly one cycle after a cycle with lk_valid high and carries that request's result. The checks run in this order: multi-hit, then miss, then privilege, then rights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rasid_we | input | 1 | Load the ring-map register |
| rasid_wdata | input | 32 | New ring-map value, byte i is ring i |
| wr_en | input | 1 | Entry write strobe |
| wr_refill | input | 1 | Write is a refill (pointer-selected way, identifier from ring) |
| wr_way | input | 2 | Way for a direct write |
| wr_vpn | input | 20 | Virtual page number of the entry; low bits pick the set |
| wr_asid | input | 8 | Identifier for a direct write |
| wr_pte | input | 32 | Page-table entry: [31:12] page, [5:4] ring, [3:0] attribute |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_store | input | 1 | Data side: 1 store, 0 load |
| lk_priv | input | 2 | Privilege index of the requester |
| rasid_q | output | 32 | Current ring-map register |
| refill_way | output | 2 | Current refill pointer |
| rsp_valid | output | 1 | Response valid |
| rsp_cause | output | 6 | 0 on success, else the fault cause |
| rsp_paddr | output | 32 | Physical address on success, else 0 |
| rsp_ring | output | 2 | Ring of the hit on success, else 0 |
| rsp_rwx | output | 3 | Granted {read, write, execute} on success, else 0 |
| rsp_cache | output | 2 | Cache mode on success, else 0 |

## Verification
The bench sweeps all sixteen attribute codes for loads, stores and fetches on both sides, so a wrong decode or a missing side mask shows up as a wrong cause or wrong rights. It crosses all four rings with all four privilege indices; an inverted or off-by-one compare would grant or refuse at the boundary. Duplicate-page entries are checked while the ring map is rewritten, which exposes a design that counts an identifier absent from the map as a hit. Refills are followed around the full pointer wrap and then overwrite an earlier entry; an off-by-one pointer or a wrong way choice leaves the old page still visible.

// File: rtl/tlb_pkg.sv
// Shared types, fault codes and the attribute decoder of the translation buffer.
// Assumes 4-bit attribute codes and four rings.
package tlb_pkg;

    typedef enum logic [1:0] {
        CACHE_BYPASS  = 2'd0,
        CACHE_WBACK   = 2'd1,
        CACHE_WTHRU   = 2'd2,
        CACHE_ISOLATE = 2'd3
    } cache_mode_e;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic        ex;
        cache_mode_e cache;
    } rights_t;

    localparam logic [5:0] CAUSE_OK         = 6'd0;
    localparam logic [5:0] CAUSE_I_MISS     = 6'd16;
    localparam logic [5:0] CAUSE_I_MULTI    = 6'd17;
    localparam logic [5:0] CAUSE_I_PRIV     = 6'd18;
    localparam logic [5:0] CAUSE_I_NOEXEC   = 6'd20;
    localparam logic [5:0] CAUSE_D_MISS     = 6'd24;
    localparam logic [5:0] CAUSE_D_MULTI    = 6'd25;
    localparam logic [5:0] CAUSE_D_PRIV     = 6'd26;
    localparam logic [5:0] CAUSE_D_NOLOAD   = 6'd28;
    localparam logic [5:0] CAUSE_D_NOSTORE  = 6'd29;

    // Map an attribute code to its unmasked rights and cache mode.
    function automatic rights_t decode_attr(input logic [3:0] code);
        rights_t r;
        r = '{rd: 1'b0, wr: 1'b0, ex: 1'b0, cache: CACHE_BYPASS};
        if (code < 4'd12) begin
            r.rd = 1'b1;
            r.ex = code[0];
            r.wr = code[1];
            case (code[3:2])
                2'd1:    r.cache = CACHE_WBACK;
                2'd2:    r.cache = CACHE_WTHRU;
                default: r.cache = CACHE_BYPASS;
            endcase
        end else if (code == 4'd13) begin
            r.rd    = 1'b1;
            r.wr    = 1'b1;
            r.cache = CACHE_ISOLATE;
        end
        return r;
    endfunction

endpackage

// File: rtl/tlb_way.sv
// One way of the buffer: NSETS entries, one write port, one combinational read.
// Assumes the set index is the low page-number bits; reset clears every entry.
module tlb_way #(
    parameter int NSETS  = 4,
    parameter int VPN_W  = 20,
    parameter int PPN_W  = 20,
    parameter int ASID_W = 8,
    localparam int IDX_W = $clog2(NSETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [3:0]        wr_attr,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [VPN_W-1:0]  rd_vpn,
    output logic              rd_match,
    output logic [ASID_W-1:0] rd_asid,
    output logic [PPN_W-1:0]  rd_ppn,
    output logic [3:0]        rd_attr
);

    logic [VPN_W-1:0]  vpn_q  [NSETS];
    logic [PPN_W-1:0]  ppn_q  [NSETS];
    logic [ASID_W-1:0] asid_q [NSETS];
    logic [3:0]        attr_q [NSETS];

    // Entry storage: cleared to invalid on reset, loaded on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSETS; s++) begin
                vpn_q[s]  <= '0;
                ppn_q[s]  <= '0;
                asid_q[s] <= '0;
                attr_q[s] <= '0;
            end
        end else if (we) begin
            vpn_q[wr_idx]  <= wr_vpn;
            ppn_q[wr_idx]  <= wr_ppn;
            asid_q[wr_idx] <= wr_asid;
            attr_q[wr_idx] <= wr_attr;
        end
    end

    // Read the addressed entry and flag a valid page match.
    always_comb begin
        rd_asid  = asid_q[rd_idx];
        rd_ppn   = ppn_q[rd_idx];
        rd_attr  = attr_q[rd_idx];
        rd_match = (vpn_q[rd_idx] == rd_vpn) && (asid_q[rd_idx] != '0);
    end

endmodule

// File: rtl/tlb_ring_find.sv
// Resolves an identifier to a ring by searching the four packed bytes of the
// ring-map register; the lowest matching byte wins. Assumes four rings.
module tlb_ring_find #(
    parameter int ASID_W = 8,
    localparam int NRING = 4
) (
    input  logic [NRING*ASID_W-1:0] ring_map,
    input  logic [ASID_W-1:0]       asid,
    output logic                    found,
    output logic [1:0]              ring
);

    // Scan from the top byte down so the lowest index is kept.
    always_comb begin
        found = 1'b0;
        ring  = 2'd0;
        for (int i = NRING - 1; i >= 0; i--) begin
            if (ring_map[i*ASID_W +: ASID_W] == asid) begin
                found = 1'b1;
                ring  = 2'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_check.sv
// Combines the per-way qualified hits into one fault cause, picks the hitting
// way, applies the side mask to the attribute rights and forms the address.
// Assumes a single page size for every way.
module tlb_check
    import tlb_pkg::*;
#(
    parameter int  NWAYS     = 4,
    parameter int  PPN_W     = 20,
    parameter int  PAGE_BITS = 12,
    parameter bit  IS_DATA   = 1'b1,
    localparam int WAY_W     = $clog2(NWAYS),
    localparam int CNT_W     = $clog2(NWAYS + 1)
) (
    input  logic [NWAYS-1:0]            qual,
    input  logic [NWAYS-1:0][1:0]       ring_w,
    input  logic [NWAYS-1:0][PPN_W-1:0] ppn_w,
    input  logic [NWAYS-1:0][3:0]       attr_w,
    input  logic [PAGE_BITS-1:0]        offset,
    input  logic                        is_store,
    input  logic [1:0]                  priv,
    output logic [5:0]                  cause,
    output logic [PPN_W+PAGE_BITS-1:0]  paddr,
    output logic [1:0]                  ring,
    output rights_t                     rights
);

    logic [CNT_W-1:0] n_hits;
    logic [WAY_W-1:0] sel;
    rights_t          raw;
    logic             have_right;

    // Count qualifying ways and remember the last one seen.
    always_comb begin
        n_hits = '0;
        sel    = '0;
        for (int w = 0; w < NWAYS; w++) begin
            if (qual[w]) begin
                n_hits = n_hits + 1'b1;
                sel    = WAY_W'(w);
            end
        end
    end

    // Decode the selected attribute and strip the rights this side never has.
    always_comb begin
        raw    = decode_attr(attr_w[sel]);
        rights = raw;
        if (IS_DATA) begin
            rights.ex = 1'b0;
        end else begin
            rights.rd = 1'b0;
            rights.wr = 1'b0;
        end
        if (IS_DATA) have_right = is_store ? rights.wr : rights.rd;
        else         have_right = rights.ex;
        ring  = ring_w[sel];
        paddr = {ppn_w[sel], offset};
    end

    // Prioritised fault selection: multi-hit, miss, privilege, rights.
    always_comb begin
        if (n_hits > CNT_W'(1))
            cause = IS_DATA ? CAUSE_D_MULTI : CAUSE_I_MULTI;
        else if (n_hits == '0)
            cause = IS_DATA ? CAUSE_D_MISS : CAUSE_I_MISS;
        else if (ring < priv)
            cause = IS_DATA ? CAUSE_D_PRIV : CAUSE_I_PRIV;
        else if (!have_right)
            cause = IS_DATA ? (is_store ? CAUSE_D_NOSTORE : CAUSE_D_NOLOAD)
                            : CAUSE_I_NOEXEC;
        else
            cause = CAUSE_OK;
    end

endmodule

// File: rtl/asid_ring_tlb.sv
// Top of the translation buffer: ring-map register, refill pointer, write
// steering, NWAYS ways with ring resolution, fault check and registered result.
// Assumes 4 rings and one page size; IS_DATA picks the data or fetch variant.
module asid_ring_tlb
    import tlb_pkg::*;
#(
    parameter int  NWAYS     = 4,
    parameter int  NSETS     = 4,
    parameter int  VA_W      = 32,
    parameter int  PAGE_BITS = 12,
    parameter int  ASID_W    = 8,
    parameter bit  IS_DATA   = 1'b1,
    localparam int WAY_W     = $clog2(NWAYS),
    localparam int IDX_W     = $clog2(NSETS),
    localparam int VPN_W     = VA_W - PAGE_BITS,
    localparam int PPN_W     = VA_W - PAGE_BITS,
    localparam int MAP_W     = 4 * ASID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rasid_we,
    input  logic [MAP_W-1:0]  rasid_wdata,
    input  logic              wr_en,
    input  logic              wr_refill,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [VA_W-1:0]   wr_pte,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_store,
    input  logic [1:0]        lk_priv,
    output logic [MAP_W-1:0]  rasid_q,
    output logic [WAY_W-1:0]  refill_way,
    output logic              rsp_valid,
    output logic [5:0]        rsp_cause,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_ring,
    output logic [2:0]        rsp_rwx,
    output logic [1:0]        rsp_cache
);

    localparam logic [MAP_W-1:0] MAP_RESET = MAP_W'(32'h0403_0201);

    logic [WAY_W-1:0]            next_ptr;
    logic [WAY_W-1:0]            tgt_way;
    logic [ASID_W-1:0]           ins_asid;
    logic [VPN_W-1:0]            lk_vpn;
    logic [NWAYS-1:0]            qual;
    logic [NWAYS-1:0][1:0]       ring_w;
    logic [NWAYS-1:0][PPN_W-1:0] ppn_w;
    logic [NWAYS-1:0][3:0]       attr_w;
    logic [5:0]                  chk_cause;
    logic [VA_W-1:0]             chk_paddr;
    logic [1:0]                  chk_ring;
    rights_t                     chk_rights;

    // Ring-map register: reset pattern, software reload.
    always_ff @(posedge clk) begin
        if (!rst_n)        rasid_q <= MAP_RESET;
        else if (rasid_we) rasid_q <= rasid_wdata;
    end

    // Refill pointer advances before each refill write.
    always_ff @(posedge clk) begin
        if (!rst_n)                  refill_way <= '0;
        else if (wr_en && wr_refill) refill_way <= next_ptr;
    end

    // Write steering: way choice and identifier for direct and refill writes.
    always_comb begin
        next_ptr = refill_way + 1'b1;
        tgt_way  = wr_refill ? next_ptr : wr_way;
        ins_asid = wr_refill ? rasid_q[wr_pte[5:4]*ASID_W +: ASID_W] : wr_asid;
        lk_vpn   = lk_vaddr[VA_W-1:PAGE_BITS];
    end

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        logic              m_raw;
        logic              r_found;
        logic [ASID_W-1:0] e_asid;

        tlb_way #(
            .NSETS (NSETS),
            .VPN_W (VPN_W),
            .PPN_W (PPN_W),
            .ASID_W(ASID_W)
        ) u_way (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (wr_en && (tgt_way == WAY_W'(w))),
            .wr_idx  (wr_vpn[IDX_W-1:0]),
            .wr_vpn  (wr_vpn),
            .wr_ppn  (wr_pte[VA_W-1:PAGE_BITS]),
            .wr_asid (ins_asid),
            .wr_attr (wr_pte[3:0]),
            .rd_idx  (lk_vpn[IDX_W-1:0]),
            .rd_vpn  (lk_vpn),
            .rd_match(m_raw),
            .rd_asid (e_asid),
            .rd_ppn  (ppn_w[w]),
            .rd_attr (attr_w[w])
        );

        tlb_ring_find #(.ASID_W(ASID_W)) u_ring (
            .ring_map(rasid_q),
            .asid    (e_asid),
            .found   (r_found),
            .ring    (ring_w[w])
        );

        assign qual[w] = m_raw && r_found;
    end

    tlb_check #(
        .NWAYS    (NWAYS),
        .PPN_W    (PPN_W),
        .PAGE_BITS(PAGE_BITS),
        .IS_DATA  (IS_DATA)
    ) u_check (
        .qual    (qual),
        .ring_w  (ring_w),
        .ppn_w   (ppn_w),
        .attr_w  (attr_w),
        .offset  (lk_vaddr[PAGE_BITS-1:0]),
        .is_store(lk_store),
        .priv    (lk_priv),
        .cause   (chk_cause),
        .paddr   (chk_paddr),
        .ring    (chk_ring),
        .rights  (chk_rights)
    );

    // Result register: outcome of the previous cycle's lookup, zeroed on fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_cause <= '0;
            rsp_paddr <= '0;
            rsp_ring  <= '0;
            rsp_rwx   <= '0;
            rsp_cache <= '0;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid) begin
                rsp_cause <= chk_cause;
                if (chk_cause == CAUSE_OK) begin
                    rsp_paddr <= chk_paddr;
                    rsp_ring  <= chk_ring;
                    rsp_rwx   <= {chk_rights.rd, chk_rights.wr, chk_rights.ex};
                    rsp_cache <= chk_rights.cache;
                end else begin
                    rsp_paddr <= '0;
                    rsp_ring  <= '0;
                    rsp_rwx   <= '0;
                    rsp_cache <= '0;
                end
            end
        end
    end

    // R8
    refill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_refill) |=> (refill_way == $past(refill_way) + 1'b1));

    // R9
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_valid));

    // R4
    ring_meets_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause == CAUSE_OK) |-> (rsp_ring >= $past(lk_priv)));

    // R6
    side_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause == CAUSE_OK) |->
            (IS_DATA ? !rsp_rwx[0] : (rsp_rwx == 3'b001)));

    // R6
    store_has_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_DATA && rsp_valid && rsp_cause == CAUSE_OK && $past(lk_store))
            |-> rsp_rwx[1]);

endmodule

// File: tb/asid_ring_tlb_bench.sv
// Sweeping bench: a data-side instance and a fetch-side instance share inputs.
module asid_ring_tlb_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rasid_we = 1'b0;
    logic [31:0] rasid_wdata = '0;
    logic        wr_en = 1'b0;
    logic        wr_refill = 1'b0;
    logic [1:0]  wr_way = '0;
    logic [19:0] wr_vpn = '0;
    logic [7:0]  wr_asid = '0;
    logic [31:0] wr_pte = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_store = 1'b0;
    logic [1:0]  lk_priv = '0;

    logic [31:0] d_map, i_map;
    logic [1:0]  d_rw, i_rw;
    logic        d_v, i_v;
    logic [5:0]  d_cause, i_cause;
    logic [31:0] d_pa, i_pa;
    logic [1:0]  d_ring, i_ring;
    logic [2:0]  d_rwx, i_rwx;
    logic [1:0]  d_cache, i_cache;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    asid_ring_tlb #(.IS_DATA(1'b1)) u_asid_ring_tlb (
        .clk(clk), .rst_n(rst_n), .rasid_we(rasid_we), .rasid_wdata(rasid_wdata),
        .wr_en(wr_en), .wr_refill(wr_refill), .wr_way(wr_way), .wr_vpn(wr_vpn),
        .wr_asid(wr_asid), .wr_pte(wr_pte), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_store(lk_store), .lk_priv(lk_priv), .rasid_q(d_map), .refill_way(d_rw),
        .rsp_valid(d_v), .rsp_cause(d_cause), .rsp_paddr(d_pa), .rsp_ring(d_ring),
        .rsp_rwx(d_rwx), .rsp_cache(d_cache));

    asid_ring_tlb #(.IS_DATA(1'b0)) u_asid_ring_tlb_i (
        .clk(clk), .rst_n(rst_n), .rasid_we(rasid_we), .rasid_wdata(rasid_wdata),
        .wr_en(wr_en), .wr_refill(wr_refill), .wr_way(wr_way), .wr_vpn(wr_vpn),
        .wr_asid(wr_asid), .wr_pte(wr_pte), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_store(lk_store), .lk_priv(lk_priv), .rasid_q(i_map), .refill_way(i_rw),
        .rsp_valid(i_v), .rsp_cause(i_cause), .rsp_paddr(i_pa), .rsp_ring(i_ring),
        .rsp_rwx(i_rwx), .rsp_cache(i_cache));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic put(input logic [1:0] way, input logic [19:0] vpn,
                       input logic [19:0] ppn, input logic [7:0] asid,
                       input logic [3:0] attr);
        @(negedge clk);
        wr_en = 1'b1; wr_refill = 1'b0; wr_way = way; wr_vpn = vpn;
        wr_asid = asid; wr_pte = {ppn, 8'h00, attr};
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [31:0] pte);
        @(negedge clk);
        wr_en = 1'b1; wr_refill = 1'b1; wr_vpn = vpn; wr_pte = pte;
        @(negedge clk) begin wr_en = 1'b0; wr_refill = 1'b0; end
    endtask

    task automatic set_map(input logic [31:0] m);
        @(negedge clk) begin rasid_we = 1'b1; rasid_wdata = m; end
        @(negedge clk) rasid_we = 1'b0;
    endtask

    // Drive one lookup; on return both responses are registered and stable.
    task automatic look(input logic [31:0] va, input logic st, input logic [1:0] pr);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_store = st; lk_priv = pr;
        @(negedge clk) lk_valid = 1'b0;
    endtask

    // Rights and cache mode of an attribute code, from the requirement text.
    function automatic logic [4:0] attr_rules(input int a);
        logic r, w, x;
        logic [1:0] c;
        r = (a < 12) || (a == 13);
        w = ((a < 12) && ((a / 2) % 2 == 1)) || (a == 13);
        x = (a < 12) && (a % 2 == 1);
        if (a == 13)     c = 2'd3;
        else if (a < 4)  c = 2'd0;
        else if (a < 8)  c = 2'd1;
        else if (a < 12) c = 2'd2;
        else             c = 2'd0;
        return {r, w, x, c};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 map", d_map, 32'h0403_0201);
        chk("R1 ptr", {30'd0, d_rw}, 0);
        look(32'h0001_0123, 1'b0, 2'd0);
        chk("R1 empty d", {26'd0, d_cause}, 24);
        chk("R1 empty i", {26'd0, i_cause}, 16);
        chk("R9 valid", {31'd0, d_v}, 1);
        @(negedge clk);
        chk("R9 drop", {31'd0, d_v}, 0);

        // R5 R6 R7 attribute sweep, both sides
        for (int a = 0; a < 16; a++) begin
            logic [4:0] ru;
            ru = attr_rules(a);
            put(2'd0, 20'h00010, 20'hABCDE, 8'd1, 4'(a));
            look(32'h0001_0123, 1'b0, 2'd0);
            chk("R6 load cause", {26'd0, d_cause}, ru[4] ? 0 : 28);
            if (ru[4]) begin
                chk("R5 load rwx", {29'd0, d_rwx}, {29'd0, ru[4], ru[3], 1'b0});
                chk("R5 cache", {30'd0, d_cache}, {30'd0, ru[1:0]});
                chk("R7 paddr", d_pa, 32'hABCD_E123);
            end
            chk("R6 fetch cause", {26'd0, i_cause}, ru[2] ? 0 : 20);
            if (ru[2]) begin
                chk("R6 fetch rwx", {29'd0, i_rwx}, 1);
                chk("R7 fetch paddr", i_pa, 32'hABCD_E123);
            end
            look(32'h0001_0123, 1'b1, 2'd0);
            chk("R6 store cause", {26'd0, d_cause}, ru[3] ? 0 : 29);
            chk("R6 store ignored on fetch side", {26'd0, i_cause}, ru[2] ? 0 : 20);
        end

        // R2 R4 ring resolution crossed with privilege
        for (int id = 1; id <= 4; id++) begin
            put(2'd0, 20'h00010, 20'hABCDE, 8'(id), 4'd7);
            for (int p = 0; p < 4; p++) begin
                look(32'h0001_0123, 1'b0, 2'(p));
                chk("R4 priv cause", {26'd0, d_cause}, (id - 1 < p) ? 26 : 0);
                chk("R4 priv cause i", {26'd0, i_cause}, (id - 1 < p) ? 18 : 0);
                if (id - 1 >= p) chk("R2 ring", {30'd0, d_ring}, 32'(id - 1));
            end
        end
        put(2'd0, 20'h00010, 20'hABCDE, 8'd5, 4'd7);
        look(32'h0001_0123, 1'b0, 2'd0);
        chk("R2 unmapped id misses", {26'd0, d_cause}, 24);
        put(2'd0, 20'h00010, 20'hABCDE, 8'd0, 4'd7);
        look(32'h0001_0123, 1'b0, 2'd0);
        chk("R2 zero id misses", {26'd0, d_cause}, 24);
        look(32'h0001_1123, 1'b0, 2'd0);
        chk("R2 other page misses", {26'd0, d_cause}, 24);

        // R3 multi-hit, and R9 ordering multi-hit over privilege
        put(2'd0, 20'h00010, 20'hABCDE, 8'd1, 4'd7);
        put(2'd1, 20'h00010, 20'h12345, 8'd2, 4'd7);
        look(32'h0001_0123, 1'b0, 2'd3);
        chk("R3 multi d", {26'd0, d_cause}, 25);
        chk("R3 multi i", {26'd0, i_cause}, 17);
        put(2'd1, 20'h00010, 20'h12345, 8'd9, 4'd7);
        look(32'h0001_0123, 1'b0, 2'd0);
        chk("R2 absent id not counted", {26'd0, d_cause}, 0);
        chk("R7 paddr way0", d_pa, 32'hABCD_E123);
        set_map(32'h0409_0201);
        chk("R2 map loaded", d_map, 32'h0409_0201);
        look(32'h0001_0123, 1'b0, 2'd0);
        chk("R3 multi after map", {26'd0, d_cause}, 25);
        set_map(32'h0403_0209);
        look(32'h0001_0123, 1'b0, 2'd0);
        chk("R2 only way1", {26'd0, d_cause}, 0);
        chk("R7 paddr way1", d_pa, 32'h1234_5123);
        chk("R2 ring byte0", {30'd0, d_ring}, 0);
        set_map(32'h0101_0101);
        put(2'd1, 20'h00010, 20'h12345, 8'd0, 4'd7);
        look(32'h0001_0123, 1'b0, 2'd0);
        chk("R2 lowest byte wins", {30'd0, d_ring}, 0);

        // R8 refill pointer, identifier from ring field, way choice
        do_reset();
        refill(20'h00020, 32'h5555_5027);
        chk("R8 ptr 1", {30'd0, d_rw}, 1);
        look(32'h0002_0abc, 1'b0, 2'd2);
        chk("R8 refill hit", {26'd0, d_cause}, 0);
        chk("R8 refill ring", {30'd0, d_ring}, 2);
        chk("R8 refill paddr", d_pa, 32'h5555_5abc);
        look(32'h0002_0abc, 1'b0, 2'd3);
        chk("R4 refill priv", {26'd0, d_cause}, 26);
        refill(20'h00021, 32'h0000_1007);
        chk("R8 ptr 2", {30'd0, d_rw}, 2);
        refill(20'h00022, 32'h0000_2007);
        chk("R8 ptr 3", {30'd0, d_rw}, 3);
        refill(20'h00023, 32'h0000_3037);
        chk("R8 ptr wrap", {30'd0, d_rw}, 0);
        look(32'h0002_3000, 1'b0, 2'd3);
        chk("R8 ring3 refill", {26'd0, d_cause}, 0);
        refill(20'h00024, 32'h6666_6017);
        look(32'h0002_0abc, 1'b0, 2'd0);
        chk("R8 overwritten way", {26'd0, d_cause}, 24);
        look(32'h0002_4abc, 1'b0, 2'd1);
        chk("R8 new entry", {26'd0, d_cause}, 0);
        chk("R8 new ring", {30'd0, d_ring}, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule